// File: doc/BRIEF.md
# Interrupt Status, Mask and Clear Register Block

This block gathers the interrupt sources of a two-wire serial bus master/slave controller into one 32-bit raw status word. Two kinds of source share that word. FIFO condition flags are levels: their raw bits track the flag inputs and cannot be cleared by software. Transaction events are sticky: a one-cycle pulse sets the raw bit, and the bit holds until software writes a one to it through the clear register. A mask register selects which raw bits count. The masked status is the raw word ANDed with the mask. A single registered interrupt line is the OR of the masked status.

Software reaches the block through a simple 32-bit register port. The port has a write strobe, a two-bit register select, write data and combinational read data. The three most significant bits of every register are reserved. A bus error event is formed inside the block: it fires when a START or STOP is seen on the bus while a transfer is active and the controller did not drive that condition itself. Transfer completion is reported on one of two status bits, depending on whether the transfer ended with a STOP. A parameter enables this split.

Top module: `irq_regblk`

## Requirements
- R1: After reset, the raw status, the mask, the masked status and `irq_o` are all zero.
- R2: The register select decodes as follows. 0 reads the raw status and is read-only. 1 reads and writes the mask. 2 reads the masked status and is read-only. 3 is the write-only clear register, which reads as zero. Bits 31:29 of the mask ignore writes, and bits 31:29 of every read are zero.
- R3: A write to the clear register affects only the bit positions in the set 0x131F007F. A one written to any other position, including bits 31:29, changes nothing.
- R4: Level bits follow `fifo_lvl_i` one clock after it is sampled, and a clear write does not change them. The input order [5:0] maps to raw bits 6, 5, 4, 2, 1, 0: RX full, RX nearly full, RX empty, TX full, TX nearly empty, TX empty.
- R5: Sticky bits are set by a one-cycle pulse and stay set until cleared. TX overrun sets bit 3. Read-from-slave request sets bit 16. Read-from-slave empty sets bit 17. Write-to-slave request sets bit 18. Slave transaction done sets bit 20. Arbitration lost sets bit 24.
- R6: When `HAS_NOSTOP_DONE` is 1, a master-done pulse sets bit 19 if `mdone_stop_i` is 1 and bit 28 if it is 0. When the parameter is 0, master-done always sets bit 19.
- R7: The bus-error bit 25 is set in a cycle where `xfer_active_i` is 1, `start_det_i` or `stop_det_i` is 1, and `own_cond_i` is 0. It is not set otherwise.
- R8: The masked status always equals raw AND mask. A write to register 2 changes neither it nor the mask.
- R9: `irq_o` is registered. It rises one clock after the masked status becomes nonzero and falls one clock after the last masked bit clears.
- R10: When a source event and a clear write hit the same sticky bit in the same cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| fifo_lvl_i | input | 6 | FIFO level flags |
| tx_ovr_i | input | 1 | TX overrun pulse |
| rd_req_i | input | 1 | Read-from-slave request pulse |
| rd_empty_i | input | 1 | Read-from-slave empty pulse |
| wr_req_i | input | 1 | Write-to-slave request pulse |
| mdone_i | input | 1 | Master transaction done pulse |
| mdone_stop_i | input | 1 | Master transaction ended with STOP |
| sdone_i | input | 1 | Slave transaction done pulse |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| start_det_i | input | 1 | START condition seen on the bus |
| stop_det_i | input | 1 | STOP condition seen on the bus |
| xfer_active_i | input | 1 | A transfer is in progress |
| own_cond_i | input | 1 | The condition seen was generated by this controller |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A source event and a software clear write can land on the same sticky bit in the same clock. The bench provokes this by raising a bus-error condition in the same cycle that it writes a one to bit 25 of the clear register. It then reads the raw status and expects bit 25 to still be set. A second overlap is a clear write that retires the last masked bit. Here the bench samples `irq_o` in the cycle after the write, when it must still be high, and again one cycle later, when it must be low.

// File: rtl/irqblk_pkg.sv
package irqblk_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;
  localparam int LVL_N  = 6;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RAW  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_MST  = 2'd2,
    SEL_CLR  = 2'd3
  } reg_sel_e;

  // bit positions of the status word
  localparam int B_TX_EMPTY   = 0;
  localparam int B_TX_NEMPTY  = 1;
  localparam int B_TX_FULL    = 2;
  localparam int B_TX_OVR     = 3;
  localparam int B_RX_EMPTY   = 4;
  localparam int B_RX_NFULL   = 5;
  localparam int B_RX_FULL    = 6;
  localparam int B_RD_REQ     = 16;
  localparam int B_RD_EMPTY   = 17;
  localparam int B_WR_REQ     = 18;
  localparam int B_MDONE      = 19;
  localparam int B_SDONE      = 20;
  localparam int B_ARB_LOST   = 24;
  localparam int B_BUS_ERR    = 25;
  localparam int B_MDONE_NS   = 28;

  localparam logic [REG_W-1:0] CLEARABLE = 32'h131F_007F;
  localparam logic [REG_W-1:0] LVL_BITS  =
    (REG_W'(1) << B_TX_EMPTY) | (REG_W'(1) << B_TX_NEMPTY) |
    (REG_W'(1) << B_TX_FULL)  | (REG_W'(1) << B_RX_EMPTY)  |
    (REG_W'(1) << B_RX_NFULL) | (REG_W'(1) << B_RX_FULL);
  localparam logic [REG_W-1:0] STICKY_BITS = CLEARABLE & ~LVL_BITS;
endpackage

// File: rtl/irq_evt_map.sv
module irq_evt_map
  import irqblk_pkg::*;
#(
  parameter bit HAS_NOSTOP_DONE = 1'b1
) (
  input  logic [LVL_N-1:0] fifo_lvl_i,
  input  logic             tx_ovr_i,
  input  logic             rd_req_i,
  input  logic             rd_empty_i,
  input  logic             wr_req_i,
  input  logic             mdone_i,
  input  logic             mdone_stop_i,
  input  logic             sdone_i,
  input  logic             arb_lost_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             xfer_active_i,
  input  logic             own_cond_i,
  output logic [REG_W-1:0] lvl_vec_o,
  output logic [REG_W-1:0] set_vec_o
);
  logic done_stop;
  logic done_nostop;
  logic bus_err;

  // completion reporting variant
  generate
    if (HAS_NOSTOP_DONE) begin : g_split_done
      assign done_stop   = mdone_i & mdone_stop_i;
      assign done_nostop = mdone_i & ~mdone_stop_i;
    end else begin : g_single_done
      logic unused_stop;
      assign unused_stop = mdone_stop_i;
      assign done_stop   = mdone_i;
      assign done_nostop = 1'b0;
    end
  endgenerate

  // a condition the controller did not drive, in mid transfer
  assign bus_err = xfer_active_i & (start_det_i | stop_det_i) & ~own_cond_i;

  always_comb begin
    lvl_vec_o              = '0;
    lvl_vec_o[B_TX_EMPTY]  = fifo_lvl_i[0];
    lvl_vec_o[B_TX_NEMPTY] = fifo_lvl_i[1];
    lvl_vec_o[B_TX_FULL]   = fifo_lvl_i[2];
    lvl_vec_o[B_RX_EMPTY]  = fifo_lvl_i[3];
    lvl_vec_o[B_RX_NFULL]  = fifo_lvl_i[4];
    lvl_vec_o[B_RX_FULL]   = fifo_lvl_i[5];
  end

  always_comb begin
    set_vec_o              = '0;
    set_vec_o[B_TX_OVR]    = tx_ovr_i;
    set_vec_o[B_RD_REQ]    = rd_req_i;
    set_vec_o[B_RD_EMPTY]  = rd_empty_i;
    set_vec_o[B_WR_REQ]    = wr_req_i;
    set_vec_o[B_MDONE]     = done_stop;
    set_vec_o[B_SDONE]     = sdone_i;
    set_vec_o[B_ARB_LOST]  = arb_lost_i;
    set_vec_o[B_BUS_ERR]   = bus_err;
    set_vec_o[B_MDONE_NS]  = done_nostop;
  end
endmodule

// File: rtl/irq_raw_reg.sv
module irq_raw_reg
  import irqblk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] lvl_vec_i,
  input  logic [REG_W-1:0] set_vec_i,
  input  logic [REG_W-1:0] clr_vec_i,
  output logic [REG_W-1:0] raw_q_o
);
  logic [REG_W-1:0] raw_d;
  logic [REG_W-1:0] raw_q;

  // set dominates clear; level bits sample their source
  always_comb begin
    raw_d = (lvl_vec_i & LVL_BITS) |
            ((set_vec_i | (raw_q & ~clr_vec_i)) & STICKY_BITS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_q_o = raw_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irqblk_pkg::*;
#(
  parameter logic [REG_W-1:0] WR_MASK = 32'h1FFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] mask_q_o
);
  logic [REG_W-1:0] mask_d;
  logic [REG_W-1:0] mask_q;

  always_comb begin
    mask_d = mask_q;
    if (wr_en_i) mask_d = wdata_i & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_q_o = mask_q;
endmodule

// File: rtl/irq_regblk.sv
module irq_regblk
  import irqblk_pkg::*;
#(
  parameter bit HAS_NOSTOP_DONE = 1'b1,
  parameter int RSVD_BITS       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [LVL_N-1:0]  fifo_lvl_i,
  input  logic              tx_ovr_i,
  input  logic              rd_req_i,
  input  logic              rd_empty_i,
  input  logic              wr_req_i,
  input  logic              mdone_i,
  input  logic              mdone_stop_i,
  input  logic              sdone_i,
  input  logic              arb_lost_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              xfer_active_i,
  input  logic              own_cond_i,
  output logic              irq_o
);
  localparam logic [REG_W-1:0] WR_MASK = {REG_W{1'b1}} >> RSVD_BITS;

  logic [REG_W-1:0] lvl_vec;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] raw_q;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] masked;
  logic             mask_we;
  logic             irq_d;
  logic             irq_q;
  reg_sel_e         sel;

  assign sel     = reg_sel_e'(reg_addr_i);
  assign mask_we = reg_wr_i && (sel == SEL_MASK);

  always_comb begin
    clr_vec = '0;
    if (reg_wr_i && (sel == SEL_CLR)) clr_vec = reg_wdata_i & CLEARABLE & WR_MASK;
  end

  irq_evt_map #(.HAS_NOSTOP_DONE(HAS_NOSTOP_DONE)) u_map (
    .fifo_lvl_i    (fifo_lvl_i),
    .tx_ovr_i      (tx_ovr_i),
    .rd_req_i      (rd_req_i),
    .rd_empty_i    (rd_empty_i),
    .wr_req_i      (wr_req_i),
    .mdone_i       (mdone_i),
    .mdone_stop_i  (mdone_stop_i),
    .sdone_i       (sdone_i),
    .arb_lost_i    (arb_lost_i),
    .start_det_i   (start_det_i),
    .stop_det_i    (stop_det_i),
    .xfer_active_i (xfer_active_i),
    .own_cond_i    (own_cond_i),
    .lvl_vec_o     (lvl_vec),
    .set_vec_o     (set_vec)
  );

  irq_raw_reg u_raw (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_vec_i (lvl_vec),
    .set_vec_i (set_vec),
    .clr_vec_i (clr_vec),
    .raw_q_o   (raw_q)
  );

  irq_mask_reg #(.WR_MASK(WR_MASK)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (mask_we),
    .wdata_i  (reg_wdata_i),
    .mask_q_o (mask_q)
  );

  assign masked = raw_q & mask_q;
  assign irq_d  = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    unique case (sel)
      SEL_RAW:  reg_rdata_o = raw_q & WR_MASK;
      SEL_MASK: reg_rdata_o = mask_q;
      SEL_MST:  reg_rdata_o = masked & WR_MASK;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_regblk_chk.sv
module irq_regblk_chk
  import irqblk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             irq_o,
  input logic [REG_W-1:0] raw_q,
  input logic [REG_W-1:0] mask_q,
  input logic [REG_W-1:0] lvl_vec,
  input logic [REG_W-1:0] set_vec,
  input logic [REG_W-1:0] clr_vec
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_o == $past(|(raw_q & mask_q))));

  // R4
  lvl_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((raw_q & LVL_BITS) == ($past(lvl_vec) & LVL_BITS)));

  // R10
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((raw_q & $past(raw_q & STICKY_BITS & ~clr_vec)) ==
                 $past(raw_q & STICKY_BITS & ~clr_vec)));

  // R2
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[REG_W-1:REG_W-3] == 3'b000);
endmodule

bind irq_regblk irq_regblk_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .raw_q       (raw_q),
  .mask_q      (mask_q),
  .lvl_vec     (lvl_vec),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec)
);

// File: tb/tb_irq_regblk.sv
`timescale 1ns/1ps
module tb_irq_regblk;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] rdata, rdata_alt;
  logic [5:0]  fifo_lvl;
  logic tx_ovr, rd_req, rd_empty, wr_req, mdone, mdone_stop, sdone, arb_lost;
  logic start_det, stop_det, xfer_active, own_cond;
  logic irq, irq_alt;
  int   vectors = 0;
  int   fails   = 0;
  bit   done    = 1'b0;

  always #4 clk = ~clk;

  irq_regblk #(.HAS_NOSTOP_DONE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .fifo_lvl_i(fifo_lvl),
    .tx_ovr_i(tx_ovr), .rd_req_i(rd_req), .rd_empty_i(rd_empty),
    .wr_req_i(wr_req), .mdone_i(mdone), .mdone_stop_i(mdone_stop),
    .sdone_i(sdone), .arb_lost_i(arb_lost), .start_det_i(start_det),
    .stop_det_i(stop_det), .xfer_active_i(xfer_active),
    .own_cond_i(own_cond), .irq_o(irq));

  irq_regblk #(.HAS_NOSTOP_DONE(1'b0)) dut_alt (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata_alt), .fifo_lvl_i(fifo_lvl),
    .tx_ovr_i(tx_ovr), .rd_req_i(rd_req), .rd_empty_i(rd_empty),
    .wr_req_i(wr_req), .mdone_i(mdone), .mdone_stop_i(mdone_stop),
    .sdone_i(sdone), .arb_lost_i(arb_lost), .start_det_i(start_det),
    .stop_det_i(stop_det), .xfer_active_i(xfer_active),
    .own_cond_i(own_cond), .irq_o(irq_alt));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_all();
    wr(2'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 raw", d, 0);
    rd(2'd1, d); chk("R1 mask", d, 0);
    rd(2'd2, d); chk("R1 masked", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R2 mask reserved", d, 32'h1FFF_FFFF);
    rd(2'd3, d); chk("R2 clear reads zero", d, 0);
    wr(2'd2, 32'h0);
    rd(2'd1, d); chk("R8 write to masked ignored", d, 32'h1FFF_FFFF);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    fifo_lvl = 6'b101011;
    step();
    rd(2'd0, d); chk("R4 level follow", d, 32'h0000_0053);
    wr(2'd3, 32'h0000_007F);
    rd(2'd0, d); chk("R4 level ignores clear", d, 32'h0000_0053);
    fifo_lvl = 6'b010100;
    step();
    rd(2'd0, d); chk("R4 level new pattern", d, 32'h0000_0024);
    fifo_lvl = 6'b0;
    step();
    rd(2'd0, d); chk("R4 level drops", d, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    tx_ovr = 1; rd_req = 1; rd_empty = 1; wr_req = 1; sdone = 1; arb_lost = 1;
    mdone = 1; mdone_stop = 1;
    step();
    tx_ovr = 0; rd_req = 0; rd_empty = 0; wr_req = 0; sdone = 0; arb_lost = 0;
    mdone = 0; mdone_stop = 0;
    step();
    rd(2'd0, d); chk("R5 sticky set and hold", d, 32'h011F_0008);
    rd_req = 1;
    step();
    rd_req = 0;
    rd(2'd0, d); chk("R5 re-pulse of a set bit", d, 32'h011F_0008);
    wr(2'd3, 32'hECE0_FF80);
    rd(2'd0, d); chk("R3 non-clearable bits ignored", d, 32'h011F_0008);
    wr(2'd3, 32'h0007_0000);
    rd(2'd0, d); chk("R3 partial clear", d, 32'h0118_0008);
    clear_all();
    rd(2'd0, d); chk("R3 full clear", d, 0);
  endtask

  task automatic t_nostop();
    logic [31:0] d;
    mdone = 1; mdone_stop = 0;
    step();
    mdone = 0;
    rd(2'd0, d); chk("R6 done without stop", d, 32'h1000_0000);
    chk("R6 variant without split", rdata_alt, 32'h0008_0000);
    clear_all();
    rd(2'd0, d); chk("R6 cleared", d, 0);
  endtask

  task automatic t_buserr();
    logic [31:0] d;
    xfer_active = 1; own_cond = 1; start_det = 1;
    step();
    rd(2'd0, d); chk("R7 own condition no error", d, 0);
    own_cond = 0; start_det = 0; xfer_active = 0; stop_det = 1;
    step();
    rd(2'd0, d); chk("R7 idle bus no error", d, 0);
    xfer_active = 1;
    step();
    stop_det = 0; xfer_active = 0;
    rd(2'd0, d); chk("R7 stop in transfer", d, 32'h0200_0000);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    tx_ovr = 1;
    step();
    tx_ovr = 0;
    chk("R9 unmasked no irq", {31'd0, irq}, 0);
    wr(2'd1, 32'h0200_0000);
    rd(2'd2, d); chk("R8 masked value", d, 32'h0200_0000);
    chk("R9 irq one cycle late", {31'd0, irq}, 0);
    step();
    chk("R9 irq high", {31'd0, irq}, 1);
    wr(2'd3, 32'h0200_0000);
    rd(2'd2, d); chk("R8 masked after clear", d, 0);
    chk("R9 irq held one cycle", {31'd0, irq}, 1);
    step();
    chk("R9 irq low", {31'd0, irq}, 0);
    rd(2'd0, d); chk("R5 other bit kept", d, 32'h0000_0008);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    xfer_active = 1; start_det = 1;
    wr(2'd3, 32'h0200_0008);
    xfer_active = 0; start_det = 0;
    rd(2'd0, d); chk("R10 event beats clear", d, 32'h0200_0000);
    step();
    chk("R10 irq from surviving bit", {31'd0, irq}, 1);
    clear_all();
    wr(2'd1, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; fifo_lvl = 0;
    tx_ovr = 0; rd_req = 0; rd_empty = 0; wr_req = 0; mdone = 0; mdone_stop = 0;
    sdone = 0; arb_lost = 0; start_det = 0; stop_det = 0; xfer_active = 0;
    own_cond = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_level();
    t_sticky();
    t_nostop();
    t_buserr();
    t_irq();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule